// File: doc/BRIEF.md
# Password-Gated Sector Write Lock

This block decides, on the contact-bus side of a dual-interface memory, whether each of the 64 user sectors may be written. An upstream serial-bus slave feeds it a decoded event stream: bus START and STOP, one pulse per received data bit, each completed byte, and the end of each acknowledge slot. From that stream the block recognises two password commands. Both are aimed at system-area address 09h/00h. Each carries a 32-bit password, then a validation code, then the same password again.

A correct presentation opens write rights. A presentation with the wrong value closes them. A write-password command sent while rights are open replaces the stored password through a storage port. The command executes only when STOP follows the final acknowledge directly. Execution takes a fixed delay, and the block asks the slave to withhold acknowledges for that time. A sector query returns the write decision: a sector is writable if its bit in the lock vector is clear, or if rights are currently open.

Top module: `pwlock_top`

## Requirements
- R1: A command frame is START, the slave byte {1010, 1, pin pair, 0}, byte 09h, byte 00h, four password bytes (most significant first), one code byte, then four repeat bytes. Each byte is counted when `i_byte_vld` pulses.
- R2: Code 09h is a presentation and code 07h is a password write. Any other code makes the frame do nothing, and `o_hold_off` stays low.
- R3: If the repeated password differs from the first copy, the frame is rejected. No delay starts and neither the rights nor the stored password change.
- R4: A valid frame executes only if `i_stop` comes after the `i_ack_end` of the twelfth byte, with no bit, byte or START event in between. A STOP anywhere else starts nothing.
- R5: Once a frame executes, `o_hold_off` is high for exactly DELAY cycles, starting the cycle after STOP. While it is high, all bus event inputs are ignored.
- R6: A presentation whose value equals `i_pw_stored` opens write rights when the delay ends. A presentation with any other value closes them.
- R7: Rights change only at the end of a presentation delay. A password write does not change them.
- R8: A password write with rights open produces one `o_pw_wr` pulse carrying the new value, in the first cycle `o_hold_off` is low again. With rights closed, it produces no pulse.
- R9: `o_sect_wr_ok` is high when bit `i_sect` of `i_lock_vec` is 0, or when rights are open. Otherwise it is low.
- R10: A frame whose slave byte has a wrong pin pair, area bit 0 or R/W 1, or whose address bytes are not 09h/00h, is ignored.
- R11: After reset, rights are closed, `o_hold_off` is low and `o_pw_wr` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset (power loss) |
| i_start | input | 1 | Bus START seen (one-cycle pulse) |
| i_stop | input | 1 | Bus STOP seen (one-cycle pulse) |
| i_bit | input | 1 | One received data bit clocked in |
| i_byte_vld | input | 1 | Byte complete, `i_byte` valid |
| i_byte | input | 8 | Received byte |
| i_ack_end | input | 1 | Acknowledge slot of the last byte finished |
| i_pins | input | 2 | Strapped device-select pin pair |
| o_hold_off | output | 1 | Internal delay running; slave must not acknowledge |
| i_sect | input | 6 | Sector index being queried |
| o_sect_wr_ok | output | 1 | Write permitted for queried sector |
| i_lock_vec | input | 64 | Per-sector lock bits from storage |
| i_pw_stored | input | 32 | Stored password from storage |
| o_pw_wr | output | 1 | Store-new-password strobe |
| o_pw_wr_data | output | 32 | New password value |

## Verification
The hardest cases to reach are near misses on execution: a well-formed frame whose STOP arrives one bit too late, or a frame that begins while the previous command's delay is still running. The bench builds both with its byte-level driver tasks. It appends a lone bit pulse before STOP, and in a separate case it launches a full wrong presentation right after a successful one, without waiting. Afterwards it reads back the open or closed rights by querying a locked sector. Stored-password changes go through a scoreboard queue. A write pulse that was not predicted is caught, and so is a predicted write that never arrives.

// File: rtl/pwlock_pkg.sv
package pwlock_pkg;
   typedef enum logic [1:0] {
      OP_NONE    = 2'd0,
      OP_PRESENT = 2'd1,
      OP_WRITE   = 2'd2
   } pw_op_e;

   localparam logic [3:0] DEV_FAMILY = 4'hA;
endpackage

// File: rtl/pwlock_frame_parser.sv
module pwlock_frame_parser
   import pwlock_pkg::*;
#(
   parameter int          PW_W       = 32,
   parameter logic [7:0]  SYS_HI     = 8'h09,
   parameter logic [7:0]  SYS_LO     = 8'h00,
   parameter logic [7:0]  CODE_SHOW  = 8'h09,
   parameter logic [7:0]  CODE_SET   = 8'h07
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            en,
   input  logic            start,
   input  logic            stop,
   input  logic            bit_in,
   input  logic            byte_vld,
   input  logic [7:0]      byte_in,
   input  logic            ack_end,
   input  logic [1:0]      pins,
   output logic            launch,
   output pw_op_e          op,
   output logic [PW_W-1:0] pw
);
   localparam int PW_BYTES  = PW_W / 8;
   localparam int IX_PW1    = 3;
   localparam int IX_CODE   = IX_PW1 + PW_BYTES;
   localparam int IX_PW2    = IX_CODE + 1;
   localparam int FRAME_LEN = IX_PW2 + PW_BYTES;
   localparam int CW        = $clog2(FRAME_LEN + 1);

   logic [CW-1:0]   cnt_q;
   logic            ok_q, armed_q;
   logic [PW_W-1:0] pw1_q, pw2_q;
   pw_op_e          op_q;
   logic [7:0]      sel_byte;
   logic            frame_good;

   assign sel_byte   = {DEV_FAMILY, 1'b1, pins, 1'b0};
   assign frame_good = ok_q && (cnt_q == CW'(FRAME_LEN)) && (pw1_q == pw2_q)
                       && (op_q != OP_NONE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q   <= '0;
         ok_q    <= 1'b0;
         armed_q <= 1'b0;
         pw1_q   <= '0;
         pw2_q   <= '0;
         op_q    <= OP_NONE;
      end else if (en) begin
         if (start) begin
            cnt_q   <= '0;
            ok_q    <= 1'b1;
            armed_q <= 1'b0;
            op_q    <= OP_NONE;
         end else if (stop) begin
            ok_q    <= 1'b0;
            armed_q <= 1'b0;
         end else begin
            if (bit_in || byte_vld) armed_q <= 1'b0;
            if (byte_vld && ok_q) begin
               if (cnt_q == CW'(FRAME_LEN)) ok_q <= 1'b0;
               else                         cnt_q <= cnt_q + 1'b1;
               if (cnt_q == CW'(0) && byte_in != sel_byte) ok_q <= 1'b0;
               if (cnt_q == CW'(1) && byte_in != SYS_HI)   ok_q <= 1'b0;
               if (cnt_q == CW'(2) && byte_in != SYS_LO)   ok_q <= 1'b0;
               if (cnt_q >= CW'(IX_PW1) && cnt_q < CW'(IX_CODE))
                  pw1_q <= {pw1_q[PW_W-9:0], byte_in};
               if (cnt_q == CW'(IX_CODE)) begin
                  if (byte_in == CODE_SHOW)     op_q <= OP_PRESENT;
                  else if (byte_in == CODE_SET) op_q <= OP_WRITE;
                  else                          ok_q <= 1'b0;
               end
               if (cnt_q >= CW'(IX_PW2) && cnt_q < CW'(FRAME_LEN))
                  pw2_q <= {pw2_q[PW_W-9:0], byte_in};
            end
            if (ack_end) armed_q <= frame_good;
         end
      end
   end

   assign launch = en && stop && armed_q;
   assign op     = op_q;
   assign pw     = pw1_q;
endmodule

// File: rtl/pwlock_exec.sv
module pwlock_exec
   import pwlock_pkg::*;
#(
   parameter int PW_W  = 32,
   parameter int DELAY = 2500
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            launch,
   input  pw_op_e          op,
   input  logic [PW_W-1:0] pw,
   input  logic [PW_W-1:0] pw_stored,
   output logic            busy,
   output logic            rights,
   output logic            wr_en,
   output logic [PW_W-1:0] wr_data
);
   localparam int DW = $clog2(DELAY + 1);

   logic [DW-1:0]   left_q;
   pw_op_e          op_q;
   logic [PW_W-1:0] pw_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy    <= 1'b0;
         rights  <= 1'b0;
         wr_en   <= 1'b0;
         wr_data <= '0;
         left_q  <= '0;
         op_q    <= OP_NONE;
         pw_q    <= '0;
      end else begin
         wr_en <= 1'b0;
         if (launch) begin
            busy   <= 1'b1;
            left_q <= DW'(DELAY - 1);
            op_q   <= op;
            pw_q   <= pw;
         end else if (busy) begin
            if (left_q == '0) begin
               busy <= 1'b0;
               if (op_q == OP_PRESENT) rights <= (pw_q == pw_stored);
               if (op_q == OP_WRITE && rights) begin
                  wr_en   <= 1'b1;
                  wr_data <= pw_q;
               end
            end else begin
               left_q <= left_q - 1'b1;
            end
         end
      end
   end
endmodule

// File: rtl/pwlock_sector_gate.sv
module pwlock_sector_gate #(
   parameter int N_SECT    = 64,
   parameter bit REG_QUERY = 1'b0
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic [$clog2(N_SECT)-1:0] sect,
   input  logic [N_SECT-1:0]         lock_vec,
   input  logic                      rights,
   output logic                      wr_ok
);
   logic decide;
   assign decide = rights || !lock_vec[sect];

   generate
      if (REG_QUERY) begin : g_reg
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) wr_ok <= 1'b0;
            else        wr_ok <= decide;
         end
      end else begin : g_comb
         assign wr_ok = decide;
      end
   endgenerate
endmodule

// File: rtl/pwlock_top.sv
module pwlock_top
   import pwlock_pkg::*;
#(
   parameter int N_SECT    = 64,
   parameter int PW_W      = 32,
   parameter int DELAY     = 2500,
   parameter bit REG_QUERY = 1'b0
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      i_start,
   input  logic                      i_stop,
   input  logic                      i_bit,
   input  logic                      i_byte_vld,
   input  logic [7:0]                i_byte,
   input  logic                      i_ack_end,
   input  logic [1:0]                i_pins,
   output logic                      o_hold_off,
   input  logic [$clog2(N_SECT)-1:0] i_sect,
   output logic                      o_sect_wr_ok,
   input  logic [N_SECT-1:0]         i_lock_vec,
   input  logic [PW_W-1:0]           i_pw_stored,
   output logic                      o_pw_wr,
   output logic [PW_W-1:0]           o_pw_wr_data
);
   generate
      if (PW_W % 8 != 0 || PW_W < 16) begin : g_bad_pw
         $error("pwlock_top: PW_W must be a multiple of 8 and at least 16");
      end
      if (DELAY < 1) begin : g_bad_delay
         $error("pwlock_top: DELAY must be at least 1");
      end
      if (N_SECT < 2 || (N_SECT & (N_SECT - 1)) != 0) begin : g_bad_sect
         $error("pwlock_top: N_SECT must be a power of two");
      end
   endgenerate

   logic            launch_w, rights_w;
   pw_op_e          op_w;
   logic [PW_W-1:0] pw_w;

   pwlock_frame_parser #(.PW_W(PW_W)) u_parse (
      .clk(clk), .rst_n(rst_n), .en(!o_hold_off),
      .start(i_start), .stop(i_stop), .bit_in(i_bit),
      .byte_vld(i_byte_vld), .byte_in(i_byte), .ack_end(i_ack_end),
      .pins(i_pins), .launch(launch_w), .op(op_w), .pw(pw_w)
   );

   pwlock_exec #(.PW_W(PW_W), .DELAY(DELAY)) u_exec (
      .clk(clk), .rst_n(rst_n), .launch(launch_w), .op(op_w), .pw(pw_w),
      .pw_stored(i_pw_stored), .busy(o_hold_off), .rights(rights_w),
      .wr_en(o_pw_wr), .wr_data(o_pw_wr_data)
   );

   pwlock_sector_gate #(.N_SECT(N_SECT), .REG_QUERY(REG_QUERY)) u_gate (
      .clk(clk), .rst_n(rst_n), .sect(i_sect), .lock_vec(i_lock_vec),
      .rights(rights_w), .wr_ok(o_sect_wr_ok)
   );
endmodule

// File: rtl/pwlock_checker.sv
module pwlock_checker #(
   parameter int N_SECT    = 64,
   parameter int DELAY     = 2500,
   parameter bit REG_QUERY = 1'b0
) (
   input logic                      clk,
   input logic                      rst_n,
   input logic                      stop,
   input logic                      busy,
   input logic                      wr,
   input logic                      rights,
   input logic [$clog2(N_SECT)-1:0] sect,
   input logic [N_SECT-1:0]         lock_vec,
   input logic                      wr_ok
);
   logic [31:0] busy_cnt;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     busy_cnt <= '0;
      else if (!busy) busy_cnt <= '0;
      else            busy_cnt <= busy_cnt + 1;
   end

   p_busy_len_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> busy_cnt == DELAY);

   p_busy_from_stop_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> $past(stop));

   p_wr_needs_rights_r8: assert property (@(posedge clk) disable iff (!rst_n)
      wr |-> ($past(rights) && $fell(busy)));

   p_rights_steady_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !$fell(busy) |-> $stable(rights));

   generate
      if (!REG_QUERY) begin : g_gate_chk
         p_gate_free_r9: assert property (@(posedge clk) disable iff (!rst_n)
            !lock_vec[sect] |-> wr_ok);
         p_gate_locked_r9: assert property (@(posedge clk) disable iff (!rst_n)
            (lock_vec[sect] && !rights) |-> !wr_ok);
      end
   endgenerate
endmodule

bind pwlock_top pwlock_checker #(.N_SECT(N_SECT), .DELAY(DELAY), .REG_QUERY(REG_QUERY)) u_chk (
   .clk(clk), .rst_n(rst_n), .stop(i_stop), .busy(o_hold_off), .wr(o_pw_wr),
   .rights(rights_w), .sect(i_sect), .lock_vec(i_lock_vec), .wr_ok(o_sect_wr_ok)
);

// File: tb/pwlock_top_tb.sv
module pwlock_top_tb;
   localparam int DLY = 20;

   logic        clk = 1'b0, rst_n = 1'b0;
   logic        i_start = 0, i_stop = 0, i_bit = 0, i_byte_vld = 0, i_ack_end = 0;
   logic [7:0]  i_byte = '0;
   logic [1:0]  i_pins = 2'b10;
   logic [5:0]  i_sect = '0;
   logic [63:0] i_lock_vec = 64'h0000_0000_0000_0025;
   logic [31:0] stored = '0;
   logic        o_hold_off, o_sect_wr_ok, o_pw_wr;
   logic [31:0] o_pw_wr_data;

   int n_run = 0, n_fail = 0;
   logic [31:0] exp_q[$];

   always #2 clk = ~clk;

   pwlock_top #(.DELAY(DLY)) u_dut (
      .clk(clk), .rst_n(rst_n), .i_start(i_start), .i_stop(i_stop), .i_bit(i_bit),
      .i_byte_vld(i_byte_vld), .i_byte(i_byte), .i_ack_end(i_ack_end),
      .i_pins(i_pins), .o_hold_off(o_hold_off), .i_sect(i_sect),
      .o_sect_wr_ok(o_sect_wr_ok), .i_lock_vec(i_lock_vec), .i_pw_stored(stored),
      .o_pw_wr(o_pw_wr), .o_pw_wr_data(o_pw_wr_data)
   );

   always @(posedge clk) if (o_pw_wr) stored <= o_pw_wr_data;

   task automatic check(input bit good, input string req, input string what,
                        input logic [63:0] act, input logic [63:0] exp);
      n_run++;
      if (!good) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   // scoreboard monitor: every store strobe must match the next predicted value
   always @(negedge clk) begin
      if (rst_n && o_pw_wr) begin
         if (exp_q.size() == 0) begin
            check(1'b0, "R8", "unexpected password store", {32'h0, o_pw_wr_data}, 64'h0);
         end else begin
            logic [31:0] e;
            e = exp_q.pop_front();
            check(o_pw_wr_data == e, "R8", "stored value", {32'h0, o_pw_wr_data}, {32'h0, e});
         end
      end
   end

   task automatic pulse_start();
      @(negedge clk) i_start = 1; @(negedge clk) i_start = 0;
   endtask

   task automatic pulse_stop();
      @(negedge clk) i_stop = 1; @(negedge clk) i_stop = 0;
   endtask

   task automatic one_bit();
      @(negedge clk) i_bit = 1; @(negedge clk) i_bit = 0;
   endtask

   task automatic send_byte(input logic [7:0] b);
      for (int k = 0; k < 7; k++) one_bit();
      @(negedge clk) begin i_bit = 1; i_byte_vld = 1; i_byte = b; end
      @(negedge clk) begin i_bit = 0; i_byte_vld = 0; end
      @(negedge clk) i_ack_end = 1;
      @(negedge clk) i_ack_end = 0;
   endtask

   // full frame; rep_n = repeat bytes sent, extra = bit pulses before STOP
   task automatic frame(input logic [7:0] sel, input logic [7:0] code,
                        input logic [31:0] p1, input logic [31:0] p2,
                        input int rep_n, input int extra, input bit wait_done,
                        output int busy_len);
      busy_len = 0;
      pulse_start();
      send_byte(sel); send_byte(8'h09); send_byte(8'h00);
      for (int k = 3; k >= 0; k--) send_byte(p1[k*8 +: 8]);
      send_byte(code);
      for (int k = 3; k >= 4 - rep_n; k--) send_byte(p2[k*8 +: 8]);
      for (int k = 0; k < extra; k++) one_bit();
      pulse_stop();
      if (wait_done) begin
         while (o_hold_off) begin busy_len++; @(negedge clk); end
         repeat (3) @(negedge clk);
      end
   endtask

   task automatic query(input int s, input bit exp, input string req);
      @(negedge clk) i_sect = 6'(s);
      #1 check(o_sect_wr_ok == exp, req, $sformatf("sector %0d write ok", s),
               {63'h0, o_sect_wr_ok}, {63'h0, exp});
   endtask

   localparam logic [7:0] SEL = 8'hAC;

   initial begin
      #(200000 * 4);
      check(1'b0, "ALL", "watchdog expired", 0, 1);
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      int bl;
      repeat (3) @(negedge clk);
      // R11: reset state
      check(o_hold_off == 0, "R11", "hold_off after reset", {63'h0, o_hold_off}, 0);
      check(o_pw_wr == 0, "R11", "store strobe after reset", {63'h0, o_pw_wr}, 0);
      rst_n = 1;
      query(5, 0, "R11");
      query(1, 1, "R9");

      // R6 R5 R1: present default password
      frame(SEL, 8'h09, 32'h0, 32'h0, 4, 0, 1, bl);
      check(bl == DLY, "R5", "delay length", bl, DLY);
      query(5, 1, "R6");

      // R8 R7: write new password with rights open
      exp_q.push_back(32'h1234_5678);
      frame(SEL, 8'h07, 32'h1234_5678, 32'h1234_5678, 4, 0, 1, bl);
      check(bl == DLY, "R4", "write delay length", bl, DLY);
      check(stored == 32'h1234_5678, "R8", "storage after write", stored, 32'h1234_5678);
      query(5, 1, "R7");

      // R6: wrong presentation closes rights
      frame(SEL, 8'h09, 32'h0, 32'h0, 4, 0, 1, bl);
      query(5, 0, "R6");
      query(0, 0, "R9");
      query(2, 0, "R9");

      // R8: write with rights closed does nothing
      frame(SEL, 8'h07, 32'hAAAA_5555, 32'hAAAA_5555, 4, 0, 1, bl);
      check(bl == DLY, "R8", "closed write still delays", bl, DLY);
      check(stored == 32'h1234_5678, "R8", "storage unchanged", stored, 32'h1234_5678);

      // R3: copies differ
      frame(SEL, 8'h09, 32'h1234_5678, 32'h1234_5679, 4, 0, 1, bl);
      check(bl == 0, "R3", "mismatched copies delay", bl, 0);
      query(5, 0, "R3");

      // R4: STOP one bit late, and STOP before the last byte
      frame(SEL, 8'h09, 32'h1234_5678, 32'h1234_5678, 4, 1, 1, bl);
      check(bl == 0, "R4", "late STOP delay", bl, 0);
      frame(SEL, 8'h09, 32'h1234_5678, 32'h1234_5678, 3, 0, 1, bl);
      check(bl == 0, "R4", "early STOP delay", bl, 0);
      query(5, 0, "R4");

      // R10: address mismatches; R2: unknown code
      frame(8'hA8, 8'h09, 32'h1234_5678, 32'h1234_5678, 4, 0, 1, bl);
      check(bl == 0, "R10", "wrong pins", bl, 0);
      frame(8'hA4, 8'h09, 32'h1234_5678, 32'h1234_5678, 4, 0, 1, bl);
      check(bl == 0, "R10", "user area bit", bl, 0);
      frame(8'hAD, 8'h09, 32'h1234_5678, 32'h1234_5678, 4, 0, 1, bl);
      check(bl == 0, "R10", "read direction", bl, 0);
      frame(SEL, 8'h05, 32'h1234_5678, 32'h1234_5678, 4, 0, 1, bl);
      check(bl == 0, "R2", "unknown code", bl, 0);
      query(5, 0, "R2");

      // R5: correct presentation, then a wrong one begun during the delay
      frame(SEL, 8'h09, 32'h1234_5678, 32'h1234_5678, 4, 0, 0, bl);
      frame(SEL, 8'h09, 32'h0, 32'h0, 4, 0, 1, bl);
      check(bl == 0, "R5", "frame started in delay", bl, 0);
      query(5, 1, "R5");
      query(0, 1, "R9");
      query(2, 1, "R9");

      // R8 R6: write back to zero, new value effective at once
      exp_q.push_back(32'h0);
      frame(SEL, 8'h07, 32'h0, 32'h0, 4, 0, 1, bl);
      check(stored == 32'h0, "R8", "storage after second write", stored, 0);
      frame(SEL, 8'h09, 32'h0, 32'h0, 4, 0, 1, bl);
      query(5, 1, "R6");

      repeat (5) @(negedge clk);
      check(exp_q.size() == 0, "R8", "pending predicted stores", exp_q.size(), 0);
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule